// File: doc/BRIEF.md
# Serial Converter Frame-Length Tracker

This block is the device-side serial port logic of a sampling converter. A host exchanges words with it over a chip-select, serial-clock, data-in, data-out link. Each exchange shifts an 8-bit instruction in on DI, most significant bit first, and shifts the previous result out on DO. The number of clock pulses that makes up one exchange is not fixed. It equals the length of the output word, and that length depends on two settings: word width (12 or 16 bits) and whether a sign bit is sent ahead of the data.

The host may pulse chip select around every exchange (strobed use) or leave it low (continuous use). In continuous use there is no framing from chip select at all. The block wraps its pulse counter each time it reaches the current expected length, so a host that sends a wrong pulse count stays out of step until reset. In strobed use, a rising chip select always ends the exchange and clears the counter. Instructions that return no conversion result may therefore stop after 8 pulses. A sticky flag records any exchange that was cut short without that permission.

The serial inputs are sampled by the system clock, which must run several times faster than SCLK. The synchronous reset stands in for cycling the supply.

Top module: `sfl_frame_tracker`

## Requirements
- R1: After reset, `frame_len_o` is 13 (12-bit word, sign bit on, MSB-first order), `desync_o` is 0 and `chan_cfg_o` is 0.
- R2: `frame_len_o` equals the word width plus one when the sign option is on: 12, 13, 16 or 17.
- R3: Opcodes (instruction bits [7:4]) 1, 2, 3 and 4 select 12-bit MSB-first, 12-bit LSB-first, 16-bit MSB-first and 16-bit LSB-first. Opcode 5 turns the sign bit on and opcode 6 turns it off. No other opcode changes the format. A change first applies to the exchange that follows the one carrying it, and `frame_len_o` does not move during an exchange.
- R4: While CS stays low, the pulse counter returns to zero after exactly `frame_len_o` rising SCLK edges, and the next rising edge carries the first instruction bit of a new exchange.
- R5: A rising CS ends the exchange and clears the counter. SCLK edges while CS is high are not counted. Calibration (opcode 8) and status-read (opcode 9) exchanges may end after 8 or more pulses without raising `desync_o`.
- R6: `desync_o` is set when CS rises with a nonzero pulse count that is either below 8 or belongs to an exchange whose opcode is not 8 or 9. Once set, it stays set until reset.
- R7: DI is sampled on rising SCLK edges. On the 8th edge of an exchange, `instr_vld_o` pulses for one clock and `instr_op_o` shows bits [7:4] of the received byte, where the first received bit is bit 7.
- R8: Opcodes 1 to 4 pulse `conv_start_o` and load `chan_cfg_o` with instruction bits [3:0]. Every other opcode leaves `chan_cfg_o` unchanged.
- R9: The output word is captured from `res_i` at the start of an exchange. Its first bit (index 0) is on DO before the first rising SCLK edge, and bit k appears after the k-th falling edge. With the sign option on, bit 0 is `res_i[15]` and the data follows it. The data is the low W bits of `res_i`, sent from bit W-1 down in MSB-first order or from bit 0 up in LSB-first order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCLK |
| rst_n | input | 1 | Synchronous active-low reset (supply cycle) |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock |
| di | input | 1 | Serial instruction input |
| res_i | input | DATA_W | Conversion result to be shifted out |
| do_o | output | 1 | Serial result output |
| instr_vld_o | output | 1 | One-clock pulse when an instruction is complete |
| instr_op_o | output | OPC_W | Opcode of the last instruction |
| chan_cfg_o | output | CHAN_W | Latched channel configuration |
| conv_start_o | output | 1 | One-clock pulse when a conversion opcode arrives |
| frame_len_o | output | CNT_W | Expected SCLK pulses for the current exchange |
| desync_o | output | 1 | Sticky flag for an illegally truncated exchange |

## Verification
The bench walks the block through every width, order and sign combination, so that a wrong length or a reversed bit order shows up as DO mismatches in the exchange right after the format change. It chains several continuous-select exchanges of different lengths. A counter that wraps one pulse early or late would shift the next instruction and decode the wrong opcode. It cuts exchanges short with calibration, status-read and conversion opcodes. A design that confused them would either miss the sticky flag or raise it on a legal short exchange. It also checks that a status read leaves the channel and format alone, and that clock edges seen while deselected are not counted.

// File: rtl/sfl_pkg.sv
// Package: shared format type, opcode values and length/bit helpers
// for the serial frame-length tracker.
package sfl_pkg;

    localparam int NARROW_W = 12;
    localparam int WIDE_W   = 16;

    localparam logic [3:0] OP_CONV12_MSB = 4'd1;
    localparam logic [3:0] OP_CONV12_LSB = 4'd2;
    localparam logic [3:0] OP_CONV16_MSB = 4'd3;
    localparam logic [3:0] OP_CONV16_LSB = 4'd4;
    localparam logic [3:0] OP_SIGN_ON    = 4'd5;
    localparam logic [3:0] OP_SIGN_OFF   = 4'd6;
    localparam logic [3:0] OP_CAL        = 4'd8;
    localparam logic [3:0] OP_STATUS     = 4'd9;

    typedef struct packed {
        logic wide;       // 1: 16-bit word, 0: 12-bit word
        logic lsb_first;  // data order on DO
        logic sign_on;    // sign bit sent ahead of the data
    } sfl_fmt_t;

    localparam sfl_fmt_t FMT_RESET = '{wide: 1'b0, lsb_first: 1'b0, sign_on: 1'b1};

    // Number of SCLK pulses one exchange takes for a given format.
    function automatic logic [4:0] fmt_len(sfl_fmt_t f);
        logic [4:0] n;
        n = f.wide ? 5'(WIDE_W) : 5'(NARROW_W);
        return n + {4'd0, f.sign_on};
    endfunction

    // True for opcodes that start a conversion.
    function automatic logic is_conv(logic [3:0] op);
        return (op >= OP_CONV12_MSB) && (op <= OP_CONV16_LSB);
    endfunction

    // True for opcodes allowed to end early in strobed use.
    function automatic logic is_short(logic [3:0] op);
        return (op == OP_CAL) || (op == OP_STATUS);
    endfunction

endpackage

// File: rtl/sfl_edge.sv
// Module: sfl_edge
// Samples SCLK and CS in the system clock domain and produces
// one-cycle edge strobes. Assumes both inputs are already synchronous
// to clk and that SCLK is much slower than clk.
module sfl_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_rise
);

    logic sclk_q;
    logic cs_q;

    // Hold last sampled levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
        end
    end

    // Edge strobes from current versus previous level.
    always_comb begin
        sclk_rise = sclk & ~sclk_q;
        sclk_fall = ~sclk & sclk_q;
        cs_rise   = cs_n & ~cs_q;
    end

endmodule

// File: rtl/sfl_frame_ctl.sv
// Module: sfl_frame_ctl
// Counts SCLK pulses per exchange, wraps at the expected length, shifts
// in the instruction byte and flags exchanges cut short illegally.
// Assumes frame_len is at least INSTR_W + 1.
module sfl_frame_ctl #(
    parameter int CNT_W   = 5,
    parameter int INSTR_W = 8,
    parameter int OPC_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_rise,
    input  logic               cs_n,
    input  logic               cs_rise,
    input  logic               di,
    input  logic [CNT_W-1:0]   frame_len,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               instr_vld_o,
    output logic [INSTR_W-1:0] instr_o,
    output logic               desync_o
);

    import sfl_pkg::*;

    localparam logic [CNT_W-1:0] INSTR_LAST = CNT_W'(INSTR_W - 1);
    localparam logic [CNT_W-1:0] INSTR_CNT  = CNT_W'(INSTR_W);

    logic [INSTR_W-1:0] shift_q;
    logic               short_ok_q;
    logic [INSTR_W-1:0] byte_in;
    logic               frame_end;
    logic               early_stop;

    // Next instruction byte and boundary conditions.
    always_comb begin
        byte_in    = {shift_q[INSTR_W-2:0], di};
        frame_end  = (cnt_o == CNT_W'(frame_len - 1'b1));
        early_stop = (cnt_o != '0) && !((cnt_o >= INSTR_CNT) && short_ok_q);
    end

    // Pulse counter, instruction shifter and sticky desync flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o       <= '0;
            shift_q     <= '0;
            short_ok_q  <= 1'b0;
            instr_vld_o <= 1'b0;
            instr_o     <= '0;
            desync_o    <= 1'b0;
        end else begin
            instr_vld_o <= 1'b0;
            if (cs_rise) begin
                cnt_o      <= '0;
                shift_q    <= '0;
                short_ok_q <= 1'b0;
                if (early_stop) begin
                    desync_o <= 1'b1;
                end
            end else if (sclk_rise && !cs_n) begin
                shift_q <= byte_in;
                if (frame_end) begin
                    cnt_o      <= '0;
                    short_ok_q <= 1'b0;
                end else begin
                    cnt_o <= cnt_o + 1'b1;
                end
                if (cnt_o == INSTR_LAST) begin
                    instr_vld_o <= 1'b1;
                    instr_o     <= byte_in;
                    short_ok_q  <= is_short(byte_in[INSTR_W-1 -: OPC_W]);
                end
            end
        end
    end

endmodule

// File: rtl/sfl_fmt_reg.sv
// Module: sfl_fmt_reg
// Decodes completed instructions into a pending output format and a
// channel setting; the pending format becomes active only between
// exchanges (counter at zero).
module sfl_fmt_reg #(
    parameter int CNT_W   = 5,
    parameter int INSTR_W = 8,
    parameter int OPC_W   = 4,
    parameter int CHAN_W  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_vld,
    input  logic [INSTR_W-1:0]   instr,
    input  logic [CNT_W-1:0]     cnt,
    output sfl_pkg::sfl_fmt_t    fmt_act_o,
    output logic [CNT_W-1:0]     frame_len_o,
    output logic [CHAN_W-1:0]    chan_cfg_o,
    output logic                 conv_start_o
);

    import sfl_pkg::*;

    sfl_fmt_t          fmt_next_q;
    logic [OPC_W-1:0]  op;

    assign op = instr[INSTR_W-1 -: OPC_W];

    // Pending format, channel latch and conversion-start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_next_q   <= FMT_RESET;
            chan_cfg_o   <= '0;
            conv_start_o <= 1'b0;
        end else begin
            conv_start_o <= 1'b0;
            if (instr_vld) begin
                if (is_conv(op)) begin
                    fmt_next_q.wide      <= (op == OP_CONV16_MSB) || (op == OP_CONV16_LSB);
                    fmt_next_q.lsb_first <= (op == OP_CONV12_LSB) || (op == OP_CONV16_LSB);
                    chan_cfg_o           <= instr[CHAN_W-1:0];
                    conv_start_o         <= 1'b1;
                end else if (op == OP_SIGN_ON) begin
                    fmt_next_q.sign_on <= 1'b1;
                end else if (op == OP_SIGN_OFF) begin
                    fmt_next_q.sign_on <= 1'b0;
                end
            end
        end
    end

    // Active format follows the pending one only between exchanges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_act_o <= FMT_RESET;
        end else if (cnt == '0) begin
            fmt_act_o <= fmt_next_q;
        end
    end

    assign frame_len_o = CNT_W'(fmt_len(fmt_act_o));

endmodule

// File: rtl/sfl_serializer.sv
// Module: sfl_serializer
// Captures the result word between exchanges and drives DO: bit 0
// while idle, bit k after the k-th falling SCLK edge.
// Assumes DATA_W is at least the wide word width.
module sfl_serializer #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_fall,
    input  logic [CNT_W-1:0]  cnt,
    input  sfl_pkg::sfl_fmt_t fmt,
    input  logic [DATA_W-1:0] res_i,
    output logic              do_o
);

    import sfl_pkg::*;

    logic [DATA_W-1:0] word_q;
    logic              do_q;

    // Bit k of the output word for a format.
    function automatic logic word_bit(logic [DATA_W-1:0] w, sfl_fmt_t f, int k);
        int width;
        int j;
        width = f.wide ? WIDE_W : NARROW_W;
        if (f.sign_on && (k == 0)) begin
            return w[DATA_W-1];
        end
        j = f.sign_on ? k - 1 : k;
        if (j >= width) begin
            return 1'b0;
        end
        return f.lsb_first ? w[j] : w[width-1-j];
    endfunction

    // Result capture between exchanges and DO update on falling edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            do_q   <= 1'b0;
        end else begin
            if (cnt == '0) begin
                word_q <= res_i;
            end
            if (sclk_fall && (cnt != '0)) begin
                do_q <= word_bit(word_q, fmt, int'(cnt));
            end
        end
    end

    assign do_o = (cnt == '0) ? word_bit(word_q, fmt, 0) : do_q;

endmodule

// File: rtl/sfl_frame_tracker.sv
// Module: sfl_frame_tracker (top)
// Device-side serial port that tracks the expected pulse count per
// exchange from the output format, decodes instructions and shifts
// results. Serial inputs must be synchronous to clk and slower than it.
module sfl_frame_tracker #(
    parameter int DATA_W  = 16,
    parameter int CNT_W   = 5,
    parameter int INSTR_W = 8,
    parameter int OPC_W   = 4,
    parameter int CHAN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              di,
    input  logic [DATA_W-1:0] res_i,
    output logic              do_o,
    output logic              instr_vld_o,
    output logic [OPC_W-1:0]  instr_op_o,
    output logic [CHAN_W-1:0] chan_cfg_o,
    output logic              conv_start_o,
    output logic [CNT_W-1:0]  frame_len_o,
    output logic              desync_o
);

    import sfl_pkg::*;

    logic               sclk_rise;
    logic               sclk_fall;
    logic               cs_rise;
    logic [CNT_W-1:0]   bit_cnt;
    logic [INSTR_W-1:0] instr;
    sfl_fmt_t           fmt_act;

    sfl_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .cs_rise   (cs_rise)
    );

    sfl_frame_ctl #(.CNT_W(CNT_W), .INSTR_W(INSTR_W), .OPC_W(OPC_W)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_rise   (sclk_rise),
        .cs_n        (cs_n),
        .cs_rise     (cs_rise),
        .di          (di),
        .frame_len   (frame_len_o),
        .cnt_o       (bit_cnt),
        .instr_vld_o (instr_vld_o),
        .instr_o     (instr),
        .desync_o    (desync_o)
    );

    sfl_fmt_reg #(.CNT_W(CNT_W), .INSTR_W(INSTR_W), .OPC_W(OPC_W), .CHAN_W(CHAN_W)) u_fmt (
        .clk          (clk),
        .rst_n        (rst_n),
        .instr_vld    (instr_vld_o),
        .instr        (instr),
        .cnt          (bit_cnt),
        .fmt_act_o    (fmt_act),
        .frame_len_o  (frame_len_o),
        .chan_cfg_o   (chan_cfg_o),
        .conv_start_o (conv_start_o)
    );

    sfl_serializer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_fall (sclk_fall),
        .cnt       (bit_cnt),
        .fmt       (fmt_act),
        .res_i     (res_i),
        .do_o      (do_o)
    );

    assign instr_op_o = instr[INSTR_W-1 -: OPC_W];

endmodule

// File: rtl/sfl_checker.sv
// Module: sfl_checker
// Temporal checks on the frame tracker, bound to every instance.
module sfl_checker #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic [CNT_W-1:0] bit_cnt,
    input logic [CNT_W-1:0] frame_len,
    input logic             desync,
    input logic             instr_vld,
    input logic             conv_start
);

    AST_CNT_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt < frame_len);  // R4

    AST_LEN_STABLE_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bit_cnt) != '0) |-> $stable(frame_len));  // R3

    AST_CS_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs_n) && $past(rst_n)) |=> (bit_cnt == '0));  // R5

    AST_DESYNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        desync |=> desync);  // R6

    AST_INSTR_AT_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        instr_vld |-> (bit_cnt == CNT_W'(8)));  // R7

    AST_CONV_AFTER_INSTR: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> $past(instr_vld));  // R8

    AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_len == CNT_W'(12)) || (frame_len == CNT_W'(13)) ||
        (frame_len == CNT_W'(16)) || (frame_len == CNT_W'(17)));  // R2

endmodule

bind sfl_frame_tracker sfl_checker #(.CNT_W(CNT_W)) u_sfl_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .bit_cnt    (bit_cnt),
    .frame_len  (frame_len_o),
    .desync     (desync_o),
    .instr_vld  (instr_vld_o),
    .conv_start (conv_start_o)
);

// File: tb/tb_sfl_frame_tracker.sv
// Scoreboard bench: the driver pushes expected DO bits into a queue,
// the monitor pops and compares them after each falling SCLK edge.
module tb_sfl_frame_tracker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        di = 1'b0;
    logic [15:0] res_i = '0;
    logic        do_o;
    logic        instr_vld_o;
    logic [3:0]  instr_op_o;
    logic [3:0]  chan_cfg_o;
    logic        conv_start_o;
    logic [4:0]  frame_len_o;
    logic        desync_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // bench model of the format
    bit          m_wide = 0;
    bit          m_lsb = 0;
    bit          m_sgn = 1;
    logic [15:0] m_res = '0;
    logic [3:0]  m_chan = '0;

    // captured decode events
    logic [3:0] last_op = '0;
    int         n_vld = 0;
    int         n_conv = 0;

    bit   exp_q[$];
    event chk_ev;

    always #2 clk = ~clk;

    sfl_frame_tracker dut (
        .clk (clk), .rst_n (rst_n), .cs_n (cs_n), .sclk (sclk), .di (di),
        .res_i (res_i), .do_o (do_o), .instr_vld_o (instr_vld_o),
        .instr_op_o (instr_op_o), .chan_cfg_o (chan_cfg_o),
        .conv_start_o (conv_start_o), .frame_len_o (frame_len_o),
        .desync_o (desync_o)
    );

    always @(posedge clk) begin
        if (instr_vld_o) begin
            last_op <= instr_op_o;
            n_vld   <= n_vld + 1;
        end
        if (conv_start_o) n_conv <= n_conv + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_len();
        return (m_wide ? 16 : 12) + (m_sgn ? 1 : 0);
    endfunction

    function automatic bit exp_bit(int k);
        int w;
        int j;
        w = m_wide ? 16 : 12;
        if (m_sgn && k == 0) return m_res[15];
        j = m_sgn ? k - 1 : k;
        if (j >= w) return 1'b0;
        return m_lsb ? m_res[j] : m_res[w-1-j];
    endfunction

    // monitor: compare DO against the queue one clock after each push
    initial begin
        forever begin
            @(chk_ev);
            @(negedge clk);
            if (exp_q.size() == 0) begin
                check("R9 queue", 1, 0);
            end else begin
                check("R9 do_o", int'(do_o), int'(exp_q.pop_front()));
            end
        end
    end

    // driver: one exchange of n pulses; strobe wraps it in CS
    task automatic xfer(input logic [7:0] ins, input int n, input bit strobe,
                        input logic [15:0] res);
        int lim;
        res_i = res;
        m_res = res;
        if (strobe) begin
            cs_n = 1'b0;
        end
        repeat (3) @(negedge clk);
        lim = (n < exp_len()) ? n : exp_len();
        exp_q.push_back(exp_bit(0));
        -> chk_ev;
        repeat (3) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            di   = (i < 8) ? ins[7-i] : 1'b0;
            sclk = 1'b1;
            repeat (4) @(negedge clk);
            sclk = 1'b0;
            repeat (2) @(negedge clk);
            if (i + 1 < lim) begin
                exp_q.push_back(exp_bit(i + 1));
                -> chk_ev;
            end
            repeat (2) @(negedge clk);
        end
        if (strobe) begin
            cs_n = 1'b1;
        end
        repeat (4) @(negedge clk);
        if (n >= 8) begin
            case (ins[7:4])
                4'd1: begin m_wide = 0; m_lsb = 0; m_chan = ins[3:0]; end
                4'd2: begin m_wide = 0; m_lsb = 1; m_chan = ins[3:0]; end
                4'd3: begin m_wide = 1; m_lsb = 0; m_chan = ins[3:0]; end
                4'd4: begin m_wide = 1; m_lsb = 1; m_chan = ins[3:0]; end
                4'd5: m_sgn = 1;
                4'd6: m_sgn = 0;
                default: ;
            endcase
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cs_n  = 1'b1;
        sclk  = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        m_wide = 0; m_lsb = 0; m_sgn = 1; m_chan = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
    end

    initial begin
        int v0;
        int c0;
        do_reset();
        check("R1 frame_len", int'(frame_len_o), 13);
        check("R1 desync", int'(desync_o), 0);
        check("R1 chan_cfg", int'(chan_cfg_o), 0);

        // R5: edges while deselected are not counted
        for (int i = 0; i < 3; i++) begin
            sclk = 1'b1; repeat (4) @(negedge clk);
            sclk = 1'b0; repeat (4) @(negedge clk);
        end
        v0 = n_vld;
        c0 = n_conv;
        xfer(8'h35, 13, 1'b1, 16'hA5C3);
        check("R7 instr_op", int'(last_op), 3);
        check("R5 one decode", n_vld - v0, 1);
        check("R8 conv_start", n_conv - c0, 1);
        check("R8 chan_cfg", int'(chan_cfg_o), 5);
        check("R2 R3 len 16+sign", int'(frame_len_o), 17);

        xfer(8'h6A, 17, 1'b1, 16'h9E17);
        check("R2 len 16", int'(frame_len_o), 16);
        check("R8 chan kept", int'(chan_cfg_o), 5);

        c0 = n_conv;
        xfer(8'h97, 8, 1'b1, 16'h1234);
        check("R5 short status", int'(desync_o), 0);
        check("R3 status keeps fmt", int'(frame_len_o), 16);
        check("R8 status chan", int'(chan_cfg_o), 5);
        check("R8 no conv", n_conv - c0, 0);

        xfer(8'h2C, 16, 1'b1, 16'h0F5A);
        check("R2 len 12", int'(frame_len_o), 12);
        check("R8 chan C", int'(chan_cfg_o), 12);

        // continuous select: frames chained by length only
        cs_n = 1'b0;
        xfer(8'h50, 12, 1'b0, 16'h3C69);
        check("R4 op sign on", int'(last_op), 5);
        check("R3 len 12+sign", int'(frame_len_o), 13);
        xfer(8'h4E, 13, 1'b0, 16'hC3A5);
        check("R4 op conv16 lsb", int'(last_op), 4);
        check("R2 len 17", int'(frame_len_o), 17);
        xfer(8'h11, 17, 1'b0, 16'h5AF0);
        check("R4 op conv12", int'(last_op), 1);
        check("R4 chan 1", int'(chan_cfg_o), 1);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R4 no desync", int'(desync_o), 0);

        xfer(8'h83, 8, 1'b1, 16'h0001);
        check("R5 short cal", int'(desync_o), 0);

        xfer(8'h12, 8, 1'b1, 16'h00FF);
        check("R6 short conv", int'(desync_o), 1);
        xfer(8'h97, 13, 1'b1, 16'h0F0F);
        check("R6 sticky", int'(desync_o), 1);

        do_reset();
        check("R1 desync cleared", int'(desync_o), 0);
        check("R1 len after reset", int'(frame_len_o), 13);
        xfer(8'h83, 5, 1'b1, 16'h0000);
        check("R6 below eight", int'(desync_o), 1);

        repeat (10) @(negedge clk);
        check("R9 queue drained", exp_q.size(), 0);
        summary();
    end

endmodule